// File: doc/BRIEF.md
# Soft Mute Fade Controller

This block ramps the attenuation of one audio path between pass-through and full mute along an S-shaped trajectory. The ramp moves gently at both ends and quickly through the middle. A mute can be requested from an asynchronous external pin or from a control register bit. The block drives an attenuation code to the analog attenuator and a status flag that software or a sequencer can watch.

Once a fade has begun it always runs to its end. While a fade is in flight, the block ignores the request inputs and the time select. It acts on the request only when it rests fully open or fully muted. The fade length comes from a 2-bit time select. A parameter chooses the table for main/sub channels (0.5, 4, 8 or 16 ms) or for speaker paths (4, 8, 32 or 64 ms).

Internally the fade is split into 2^STEP_W phases. Each phase lasts `M × TICK_DIV` clocks, where M is the phase multiplier from the active table. The curve value is computed from the phase number.

Top module: `softmute_ctrl`

## Requirements
- R1: After synchronous reset, `atten_o` is 0 and `muted_o` is 0.
- R2: The effective request is `mute_reg_i` OR the pin after a two-flop synchronizer. A register request starts a fade on the first clock edge that sees it. A pin request starts it on the third edge.
- R3: During a fade-down entered at edge E, after edge E+k the attenuation equals floor(MUTE_ATT·(3p²N − 2p³)/N³), where N = 2^STEP_W and p = floor(k/(M·TICK_DIV)).
- R4: During a fade-up entered at edge E, after edge E+k the attenuation is the same formula evaluated at N − p. It therefore starts at MUTE_ATT and falls.
- R5: With SPEAKER_PATH=0, the multiplier M for time select 0,1,2,3 is 1,8,16,32. A fade lasts N·M·TICK_DIV clocks, which equals 0.5/4/8/16 ms when one tick is 0.5 ms/N.
- R6: With SPEAKER_PATH=1, M for time select 0,1,2,3 is 8,16,64,128, which gives 4/8/32/64 ms.
- R7: A change of the request during a fade is ignored until that fade completes. A fade-down always reaches MUTE_ATT, and a fade-up always reaches 0. The request is then evaluated on the next edge.
- R8: The time select is captured when a fade starts. A change to it during the fade does not alter that fade's length.
- R9: `muted_o` is 1 from the edge that starts a fade-down until the edge that ends the following fade-up, inclusive of the fully muted interval.
- R10: When fully muted, `atten_o` equals MUTE_ATT (default 100, at least 80 dB). It stays there for as long as the request is held.
- R11: While unmuted, `atten_o` is 0 regardless of time select changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mute_pin_i | input | 1 | Asynchronous external mute request, active high |
| mute_reg_i | input | 1 | Register mute request, active high |
| time_sel_i | input | 2 | Fade length select |
| atten_o | output | 7 | Attenuation code in dB, 0 = pass-through |
| muted_o | output | 1 | Mute activity status |

## Verification
The bench builds one main-channel instance and one speaker-path instance. Both use TICK_DIV=2 and STEP_W=3, so the longest speaker fade lasts 2048 clocks and every time select of both tables fits in a short run. The small phase count keeps each of the eight curve points visible. The bench can therefore check the S-curve value in every cycle of every fade, and it can place a request or time-select change in the middle of a fade.

// File: rtl/softmute_pkg.sv
package softmute_pkg;

    localparam int ATT_W  = 7;
    localparam int MULT_W = 8;

    typedef enum logic [1:0] {
        ST_OPEN = 2'd0,
        ST_DOWN = 2'd1,
        ST_SHUT = 2'd2,
        ST_UP   = 2'd3
    } fade_st_t;

    // ticks spent in each curve phase; base tick is (0.5 ms / phases)
    function automatic logic [MULT_W-1:0] ticks_per_phase(input bit speaker,
                                                           input logic [1:0] sel);
        logic [MULT_W-1:0] m;
        if (speaker) begin
            case (sel)
                2'd0:    m = MULT_W'(8);
                2'd1:    m = MULT_W'(16);
                2'd2:    m = MULT_W'(64);
                default: m = MULT_W'(128);
            endcase
        end else begin
            case (sel)
                2'd0:    m = MULT_W'(1);
                2'd1:    m = MULT_W'(8);
                2'd2:    m = MULT_W'(16);
                default: m = MULT_W'(32);
            endcase
        end
        return m;
    endfunction

    // smoothstep 3x^2 - 2x^3 scaled to the full mute code
    function automatic logic [ATT_W-1:0] s_curve(input int unsigned p,
                                                  input int unsigned n,
                                                  input int unsigned full);
        int unsigned num;
        num = full * (3 * p * p * n - 2 * p * p * p);
        return ATT_W'(num / (n * n * n));
    endfunction

endpackage

// File: rtl/mute_req_sync.sv
module mute_req_sync (
    input  logic clk,
    input  logic rst,
    input  logic pin_i,
    input  logic reg_i,
    output logic req_o
);
    logic [1:0] sync_q;

    always_ff @(posedge clk) begin
        if (rst) sync_q <= 2'b00;
        else     sync_q <= {sync_q[0], pin_i};
    end

    assign req_o = sync_q[1] | reg_i;
endmodule

// File: rtl/fade_timer.sv
module fade_timer
    import softmute_pkg::*;
#(
    parameter int TICK_DIV = 375
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run_i,
    input  logic [MULT_W-1:0] tpp_i,
    output logic              adv_o
);
    localparam int PRE_W = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICK_DIV - 1);

    logic [PRE_W-1:0]  pre_q;
    logic [MULT_W-1:0] stp_q;
    logic              tick;
    logic              stp_last;

    assign tick     = (pre_q == PRE_LAST);
    assign stp_last = (stp_q == (tpp_i - MULT_W'(1)));

    always_ff @(posedge clk) begin
        if (rst || !run_i) begin
            pre_q <= '0;
            stp_q <= '0;
        end else if (tick) begin
            pre_q <= '0;
            stp_q <= stp_last ? '0 : stp_q + MULT_W'(1);
        end else begin
            pre_q <= pre_q + PRE_W'(1);
        end
    end

    assign adv_o = run_i && tick && stp_last;
endmodule

// File: rtl/mute_fsm.sv
module mute_fsm
    import softmute_pkg::*;
#(
    parameter int STEP_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_i,
    input  logic              adv_i,
    output fade_st_t          st_o,
    output logic [STEP_W-1:0] phase_o
);
    localparam logic [STEP_W-1:0] PH_LAST = '1;

    fade_st_t          st_q;
    logic [STEP_W-1:0] ph_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= ST_OPEN;
            ph_q <= '0;
        end else begin
            case (st_q)
                ST_OPEN: if (req_i) begin
                    st_q <= ST_DOWN;
                    ph_q <= '0;
                end
                ST_SHUT: if (!req_i) begin
                    st_q <= ST_UP;
                    ph_q <= '0;
                end
                ST_DOWN: if (adv_i) begin
                    if (ph_q == PH_LAST) begin
                        st_q <= ST_SHUT;
                        ph_q <= '0;
                    end else begin
                        ph_q <= ph_q + STEP_W'(1);
                    end
                end
                default: if (adv_i) begin
                    if (ph_q == PH_LAST) begin
                        st_q <= ST_OPEN;
                        ph_q <= '0;
                    end else begin
                        ph_q <= ph_q + STEP_W'(1);
                    end
                end
            endcase
        end
    end

    assign st_o    = st_q;
    assign phase_o = ph_q;
endmodule

// File: rtl/softmute_ctrl.sv
module softmute_ctrl
    import softmute_pkg::*;
#(
    parameter bit SPEAKER_PATH = 1'b0,
    parameter int TICK_DIV     = 375,
    parameter int STEP_W       = 5,
    parameter int MUTE_ATT     = 100
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             mute_pin_i,
    input  logic             mute_reg_i,
    input  logic [1:0]       time_sel_i,
    output logic [ATT_W-1:0] atten_o,
    output logic             muted_o
);
    localparam int unsigned NSTEPS = 1 << STEP_W;

    logic              req_eff;
    logic              adv;
    logic              run;
    fade_st_t          st_q;
    logic [STEP_W-1:0] phase_q;
    logic [1:0]        sel_q;
    logic [MULT_W-1:0] tpp;

    mute_req_sync u_sync (
        .clk   (clk),
        .rst   (rst),
        .pin_i (mute_pin_i),
        .reg_i (mute_reg_i),
        .req_o (req_eff)
    );

    // time select follows the input only while resting; frozen during a fade
    always_ff @(posedge clk) begin
        if (rst)                                     sel_q <= 2'd0;
        else if (st_q == ST_OPEN || st_q == ST_SHUT) sel_q <= time_sel_i;
    end

    assign tpp = ticks_per_phase(SPEAKER_PATH, sel_q);
    assign run = (st_q == ST_DOWN) || (st_q == ST_UP);

    fade_timer #(.TICK_DIV(TICK_DIV)) u_timer (
        .clk   (clk),
        .rst   (rst),
        .run_i (run),
        .tpp_i (tpp),
        .adv_o (adv)
    );

    mute_fsm #(.STEP_W(STEP_W)) u_fsm (
        .clk     (clk),
        .rst     (rst),
        .req_i   (req_eff),
        .adv_i   (adv),
        .st_o    (st_q),
        .phase_o (phase_q)
    );

    always_comb begin
        case (st_q)
            ST_OPEN: atten_o = '0;
            ST_SHUT: atten_o = ATT_W'(MUTE_ATT);
            ST_DOWN: atten_o = s_curve(int'(phase_q), NSTEPS, MUTE_ATT);
            default: atten_o = s_curve(NSTEPS - int'(phase_q), NSTEPS, MUTE_ATT);
        endcase
    end

    assign muted_o = (st_q != ST_OPEN);
endmodule

// File: rtl/softmute_chk.sv
module softmute_chk
    import softmute_pkg::*;
#(
    parameter int MUTE_ATT = 100
) (
    input logic             clk,
    input logic             rst,
    input fade_st_t         st,
    input logic [1:0]       sel_q,
    input logic [ATT_W-1:0] att,
    input logic             flag
);
    a_r11_open_zero: assert property (@(posedge clk) disable iff (rst)
        !flag |-> att == '0);

    a_r9_flag_starts_fade: assert property (@(posedge clk) disable iff (rst)
        $rose(flag) |-> st == ST_DOWN);

    a_r7_down_runs_out: assert property (@(posedge clk) disable iff (rst)
        st == ST_DOWN |=> (st == ST_DOWN || st == ST_SHUT));

    a_r7_up_runs_out: assert property (@(posedge clk) disable iff (rst)
        st == ST_UP |=> (st == ST_UP || st == ST_OPEN));

    a_r3_down_monotone: assert property (@(posedge clk) disable iff (rst)
        (st == ST_DOWN && $past(st) == ST_DOWN) |-> att >= $past(att));

    a_r4_up_monotone: assert property (@(posedge clk) disable iff (rst)
        (st == ST_UP && $past(st) == ST_UP) |-> att <= $past(att));

    a_r8_sel_frozen: assert property (@(posedge clk) disable iff (rst)
        (st == ST_DOWN && $past(st) == ST_DOWN) |-> $stable(sel_q));

    a_r10_code_bound: assert property (@(posedge clk) disable iff (rst)
        att <= ATT_W'(MUTE_ATT));
endmodule

bind softmute_ctrl softmute_chk #(.MUTE_ATT(MUTE_ATT)) u_chk (
    .clk   (clk),
    .rst   (rst),
    .st    (st_q),
    .sel_q (sel_q),
    .att   (atten_o),
    .flag  (muted_o)
);

// File: tb/sim_softmute_ctrl.sv
module sim_softmute_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int DIV  = 2;
    localparam int SW   = 3;
    localparam int N    = 1 << SW;
    localparam int FULL = 100;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic pin_v [2];
    logic reg_v [2];
    logic [1:0] sel_v [2];
    logic [6:0] att0, att1;
    logic flag0, flag1;
    int total = 0;
    int bad   = 0;
    bit done  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    softmute_ctrl #(.SPEAKER_PATH(1'b0), .TICK_DIV(DIV), .STEP_W(SW), .MUTE_ATT(FULL)) u0 (
        .clk(clk), .rst(rst), .mute_pin_i(pin_v[0]), .mute_reg_i(reg_v[0]),
        .time_sel_i(sel_v[0]), .atten_o(att0), .muted_o(flag0));

    softmute_ctrl #(.SPEAKER_PATH(1'b1), .TICK_DIV(DIV), .STEP_W(SW), .MUTE_ATT(FULL)) u1 (
        .clk(clk), .rst(rst), .mute_pin_i(pin_v[1]), .mute_reg_i(reg_v[1]),
        .time_sel_i(sel_v[1]), .atten_o(att1), .muted_o(flag1));

    function automatic int mult_of(int inst, int sel);
        if (inst == 1) return (sel == 0) ? 8 : (sel == 1) ? 16 : (sel == 2) ? 64 : 128;
        return (sel == 0) ? 1 : (sel == 1) ? 8 : (sel == 2) ? 16 : 32;
    endfunction

    function automatic int curve(int p);
        return (FULL * (3 * p * p * N - 2 * p * p * p)) / (N * N * N);
    endfunction

    function automatic int att_of(int inst);
        return (inst == 1) ? int'(att1) : int'(att0);
    endfunction

    function automatic bit flag_of(int inst);
        return (inst == 1) ? flag1 : flag0;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic set_req(input int inst, input bit use_pin, input bit v);
        if (use_pin) pin_v[inst] = v;
        else         reg_v[inst] = v;
    endtask

    // request a mute and follow the whole fade-down
    task automatic go_down(input int inst, input bit use_pin, input int sel, input bit rel_mid);
        int lat = use_pin ? 3 : 1;
        int md  = mult_of(inst, sel) * DIV;
        int t   = N * md;
        int early = 0, mism = 0, a_act = 0, a_exp = 0, flag_bad = 0;
        sel_v[inst] = 2'(sel);
        set_req(inst, use_pin, 1'b1);
        for (int e = 1; e < lat; e++) begin
            step();
            if (flag_of(inst)) early++;
        end
        chk(early == 0, "R2 fade waits for synchronizer", early, 0);
        step();
        for (int k = 0; k < t; k++) begin
            if (att_of(inst) != curve(k / md) && mism == 0) begin
                a_act = att_of(inst);
                a_exp = curve(k / md);
                mism++;
            end
            if (!flag_of(inst)) flag_bad++;
            if (rel_mid && k == t / 2) begin
                set_req(inst, use_pin, 1'b0);
                sel_v[inst] = sel_v[inst] ^ 2'b01;
            end
            step();
        end
        chk(mism == 0, rel_mid ? "R7 fade-down trajectory despite release" : "R3 fade-down trajectory",
            a_act, a_exp);
        chk(flag_bad == 0, "R9 flag during fade-down", flag_bad, 0);
        chk(att_of(inst) == FULL && flag_of(inst),
            inst == 1 ? "R6 speaker fade length" : "R5 main fade length", att_of(inst), FULL);
        if (rel_mid) chk(att_of(inst) == FULL, "R8 length fixed at start", att_of(inst), FULL);
    endtask

    // follow a fade-up from the muted state
    task automatic go_up(input int inst, input bit use_pin, input bit release_now, input bit rereq_mid);
        int sel = int'(sel_v[inst]);
        int lat = (release_now && use_pin) ? 3 : 1;
        int md  = mult_of(inst, sel) * DIV;
        int t   = N * md;
        int mism = 0, a_act = 0, a_exp = 0, flag_bad = 0, hold_bad = 0;
        if (release_now) set_req(inst, use_pin, 1'b0);
        for (int e = 1; e < lat; e++) begin
            step();
            if (att_of(inst) != FULL) hold_bad++;
        end
        chk(hold_bad == 0, "R2 pin release waits for synchronizer", hold_bad, 0);
        step();
        for (int k = 0; k < t; k++) begin
            if (att_of(inst) != curve(N - k / md) && mism == 0) begin
                a_act = att_of(inst);
                a_exp = curve(N - k / md);
                mism++;
            end
            if (!flag_of(inst)) flag_bad++;
            if (rereq_mid && k == t / 2) reg_v[inst] = 1'b1;
            step();
        end
        chk(mism == 0, rereq_mid ? "R7 fade-up trajectory despite request" : "R4 fade-up trajectory",
            a_act, a_exp);
        chk(flag_bad == 0, "R9 flag during fade-up", flag_bad, 0);
        chk(att_of(inst) == 0 && !flag_of(inst), "R9 flag clears at end of fade-up",
            int'(flag_of(inst)), 0);
        if (rereq_mid) begin
            step();
            chk(flag_of(inst) && att_of(inst) == 0, "R7 pending request acted on after completion",
                int'(flag_of(inst)), 1);
            reg_v[inst] = 1'b0;
            for (int w = 0; w < 20000 && flag_of(inst); w++) step();
        end
    endtask

    initial begin
        for (int i = 0; i < 2; i++) begin
            pin_v[i] = 1'b0;
            reg_v[i] = 1'b0;
            sel_v[i] = 2'd0;
        end
        void'($urandom(32'd4711));
        repeat (3) step();
        rst = 1'b0;
        step();
        chk(att0 == 0 && !flag0, "R1 reset main", int'(att0), 0);
        chk(att1 == 0 && !flag1, "R1 reset speaker", int'(att1), 0);

        // R11: time select changes while open leave the output alone
        for (int s = 0; s < 4; s++) begin
            sel_v[0] = 2'(s);
            step();
        end
        chk(att0 == 0 && !flag0, "R11 idle ignores time select", int'(att0), 0);

        // directed: register request, shortest main fade, hold fully muted
        go_down(0, 1'b0, 0, 1'b0);
        begin
            int hold_bad = 0;
            for (int h = 0; h < 10; h++) begin
                step();
                if (att0 != 7'(FULL)) hold_bad++;
            end
            chk(hold_bad == 0, "R10 mute held while requested", hold_bad, 0);
        end
        go_up(0, 1'b0, 1'b1, 1'b0);

        // directed: pin request, longest main fade
        go_down(0, 1'b1, 3, 1'b0);
        go_up(0, 1'b1, 1'b1, 1'b0);

        // directed: speaker, release and time-select change mid fade-down
        go_down(1, 1'b0, 2, 1'b1);
        go_up(1, 1'b0, 1'b0, 1'b0);

        // directed: request re-asserted mid fade-up
        go_down(0, 1'b0, 1, 1'b0);
        go_up(0, 1'b0, 1'b1, 1'b1);

        // directed: speaker pin release mid fade-down
        go_down(1, 1'b1, 0, 1'b1);
        go_up(1, 1'b1, 1'b0, 1'b0);

        // random mix
        for (int r = 0; r < 10; r++) begin
            int inst = int'($urandom % 2);
            bit up   = 1'($urandom % 2);
            int sel  = int'($urandom % 4);
            bit rel  = 1'($urandom % 2);
            go_down(inst, up, sel, rel);
            go_up(inst, up, !rel, 1'b0);
        end

        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule